// File: doc/BRIEF.md
# Sized-Access General-Purpose Register Bank

This block is a bank of sixteen 64-bit general-purpose registers with two read ports and one write port. Each port takes its own access size, so a read or a write can touch the low 8, 16, 32 or 64 bits of any register. Reads return the selected low bits, zero-padded to 64 bits.

The write path holds an extension stage that serves three kinds of move. A plain move writes the low bits of the operand at the destination size. A zero-extending move and a sign-extending move take a narrower source field and widen it to the destination size. A write always clears every bit above the destination size, so a full 64-bit immediate load is a plain move at the 64-bit size. Only a fixed set of source and destination size pairs is accepted for the extending moves. A pair outside that set raises an error and the write does not happen.

One register is the stack pointer, chosen by a parameter. A committed write to it whose value is not a multiple of 8 raises an alignment fault for that cycle.

Top module: `gpr_bank`

## Requirements
- R1: After reset, every register reads as zero on both read ports at every size.
- R2: The size code on each read port selects the bits returned: 0 gives bits 7:0, 1 gives bits 15:0, 2 gives bits 31:0 and 3 gives bits 63:0. All bits above the selected size read as zero.
- R3: When wr_mode is 0 (plain move), the write stores the low bits of wr_data at the size wr_dst_size and clears every higher bit of the register. wr_src_size is ignored, and every size is legal.
- R4: When wr_mode is 2 (sign-extending), the legal pairs are those where the source size code is below the destination size code. The stored value is the source field with its top bit copied up to the top of the destination size, and zeros above that.
- R5: When wr_mode is 1 (zero-extending), the legal pairs are those where the source size code is below the destination size code, except source 2 with destination 3. The stored value is the source field with zeros above it.
- R6: When wr_en is high and the pair is illegal, wr_ext_err is high in that same cycle and the target register keeps its value. Illegal pairs are a source size not below the destination size in modes 1 and 2, source 2 with destination 3 in mode 1, and every pair in mode 3. wr_ext_err is low whenever wr_en is low.
- R7: sp_misalign is high in a cycle exactly when a legal write to register SP_IDX (default 4) is being committed and bits 2:0 of the value being stored are not all zero. The write still takes place.
- R8: A read of a register that is being written in the same cycle returns the old contents. The new value is visible from the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_size | input | 2 | Read port A size code |
| rd_a_data | output | 64 | Read port A data, zero-padded |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_size | input | 2 | Read port B size code |
| rd_b_data | output | 64 | Read port B data, zero-padded |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_mode | input | 2 | 0 plain, 1 zero-extend, 2 sign-extend, 3 reserved |
| wr_src_size | input | 2 | Source field size code for extending moves |
| wr_dst_size | input | 2 | Destination size code |
| wr_data | input | 64 | Write operand |
| wr_ext_err | output | 1 | Illegal size pair on the current write |
| sp_misalign | output | 1 | Stack pointer written with a value not a multiple of 8 |

## Verification
On every cycle, the assertions check the shape of the value leaving the extension stage: the bits above the destination size are clear, the sign bit is copied in sign mode, and no bits are set above the source field in zero mode. They also check that the long-to-quad zero pair is refused, that the read ports pad with zeros, that a committed write lands in storage, and that the fault only goes with a legal write to the stack pointer. The bench sweeps every mode and size pair with a negative and a positive operand. This sweep is what shows the full legal set, that a refused write leaves the old contents in place, that every register resets to zero, and that a read and a write to the same register in one cycle return the old value.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int XLEN = 64;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_DBL = 2'd3} acc_size_e;
  typedef enum logic [1:0] {MV_PLAIN = 2'd0, MV_ZERO = 2'd1, MV_SIGN = 2'd2, MV_RSVD = 2'd3} mv_mode_e;

  function automatic logic [XLEN-1:0] size_mask(logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 64'h0000_0000_0000_00FF;
      2'd1:    size_mask = 64'h0000_0000_0000_FFFF;
      2'd2:    size_mask = 64'h0000_0000_FFFF_FFFF;
      default: size_mask = '1;
    endcase
  endfunction

  function automatic int top_bit(logic [1:0] sz);
    top_bit = (8 << sz) - 1;
  endfunction

  function automatic logic pair_legal(logic [1:0] mode, logic [1:0] src, logic [1:0] dst);
    case (mode)
      MV_PLAIN: pair_legal = 1'b1;
      MV_SIGN:  pair_legal = (src < dst);
      MV_ZERO:  pair_legal = (src < dst) && !(src == SZ_WORD && dst == SZ_DBL);
      default:  pair_legal = 1'b0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] extend_value(logic [1:0] mode, logic [1:0] src,
                                                   logic [1:0] dst, logic [XLEN-1:0] din);
    logic [1:0]      field;
    logic [XLEN-1:0] v;
    field = (mode == MV_PLAIN) ? dst : src;
    v = din & size_mask(field);
    if (mode == MV_SIGN && din[top_bit(field)]) v = v | ~size_mask(field);
    extend_value = v & size_mask(dst);
  endfunction
endpackage

// File: rtl/gpr_ext_unit.sv
module gpr_ext_unit
  import gpr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic [1:0]      src_size,
  input  logic [1:0]      dst_size,
  input  logic [XLEN-1:0] din,
  output logic            legal,
  output logic [XLEN-1:0] dout
);
  assign legal = pair_legal(mode, src_size, dst_size);
  assign dout  = extend_value(mode, src_size, dst_size, din);

  AST_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    legal |-> (dout & ~size_mask(dst_size)) == '0); // R3
  AST_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && mode == MV_SIGN) |-> dout[top_bit(dst_size)] == din[top_bit(src_size)]); // R4
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (legal && mode == MV_ZERO) |-> (dout & ~size_mask(src_size)) == '0); // R5
  AST_NO_WORD_TO_DBL_ZX: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MV_ZERO && src_size == SZ_WORD && dst_size == SZ_DBL) |-> !legal); // R5
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
  import gpr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      size,
  input  logic [XLEN-1:0] word,
  output logic [XLEN-1:0] data
);
  assign data = word & size_mask(size);

  AST_READ_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (size != SZ_DBL) |-> data[XLEN-1:32] == '0); // R2
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage
  import gpr_pkg::*;
#(
  parameter int NREG = 16,
  parameter int NRD  = 2,
  localparam int IW  = $clog2(NREG)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [IW-1:0]   widx,
  input  logic [XLEN-1:0] wdata,
  input  logic [IW-1:0]   ridx  [NRD],
  output logic [XLEN-1:0] rword [NRD]
);
  logic [XLEN-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rword[g] = mem[ridx[g]];
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(widx)] == $past(wdata)); // R8
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int SP_IDX = 4,
  localparam int IW    = $clog2(NREG)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   rd_a_idx,
  input  logic [1:0]      rd_a_size,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [IW-1:0]   rd_b_idx,
  input  logic [1:0]      rd_b_size,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [1:0]      wr_mode,
  input  logic [1:0]      wr_src_size,
  input  logic [1:0]      wr_dst_size,
  input  logic [XLEN-1:0] wr_data,
  output logic            wr_ext_err,
  output logic            sp_misalign
);
  localparam int NRD = 2;

  logic            pair_ok;
  logic [XLEN-1:0] ext_val;
  logic            commit;
  logic            sp_hit;
  logic [IW-1:0]   ridx  [NRD];
  logic [1:0]      rsize [NRD];
  logic [XLEN-1:0] rword [NRD];
  logic [XLEN-1:0] rdata [NRD];

  gpr_ext_unit u_ext (
    .clk(clk), .rst_n(rst_n), .mode(wr_mode), .src_size(wr_src_size),
    .dst_size(wr_dst_size), .din(wr_data), .legal(pair_ok), .dout(ext_val)
  );

  assign commit      = wr_en && pair_ok;
  assign wr_ext_err  = wr_en && !pair_ok;
  assign sp_hit      = (wr_idx == IW'(SP_IDX));
  assign sp_misalign = commit && sp_hit && (ext_val[2:0] != 3'd0);

  gpr_storage #(.NREG(NREG), .NRD(NRD)) u_store (
    .clk(clk), .rst_n(rst_n), .we(commit), .widx(wr_idx), .wdata(ext_val),
    .ridx(ridx), .rword(rword)
  );

  assign ridx[0]  = rd_a_idx;
  assign ridx[1]  = rd_b_idx;
  assign rsize[0] = rd_a_size;
  assign rsize[1] = rd_b_size;

  for (genvar g = 0; g < NRD; g++) begin : g_port
    gpr_read_port u_rp (
      .clk(clk), .rst_n(rst_n), .size(rsize[g]), .word(rword[g]), .data(rdata[g])
    );
  end

  assign rd_a_data = rdata[0];
  assign rd_b_data = rdata[1];

  AST_FAULT_ON_SP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sp_misalign |-> (wr_en && wr_idx == IW'(SP_IDX) && !wr_ext_err)); // R7
  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ext_err |-> wr_en); // R6
endmodule

// File: tb/sim_gpr_bank.sv
module sim_gpr_bank;
  localparam int CLK_NS = 10;
  localparam logic [63:0] PRE  = 64'hDEAD_BEEF_CAFE_F00D;
  localparam logic [63:0] NEG  = 64'hF3E2_D1C0_B7A6_9584;
  localparam logic [63:0] POS  = 64'h1C2D_3E4F_5061_7203;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [1:0]  rd_a_size = '0, rd_b_size = '0, wr_mode = '0, wr_src_size = '0, wr_dst_size = '0;
  logic [63:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0;
  logic        wr_ext_err, sp_misalign;
  int checks = 0;
  int failures = 0;

  always #(CLK_NS/2) clk = ~clk;

  gpr_bank u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_size(rd_a_size), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_size(rd_b_size), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_mode(wr_mode), .wr_src_size(wr_src_size),
    .wr_dst_size(wr_dst_size), .wr_data(wr_data),
    .wr_ext_err(wr_ext_err), .sp_misalign(sp_misalign)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] m_mask(int sz);
    int w = 8 << sz;
    return (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic bit m_legal(int mode, int s, int d);
    if (mode == 0) return 1;
    if (mode == 3) return 0;
    if (s >= d) return 0;
    if (mode == 1 && s == 2 && d == 3) return 0;
    return 1;
  endfunction

  function automatic logic [63:0] m_value(int mode, int s, int d, logic [63:0] x);
    logic [63:0] v;
    if (mode == 0) return x & m_mask(d);
    v = x & m_mask(s);
    if (mode == 2 && x[(8 << s) - 1]) v = v | ~m_mask(s);
    return v & m_mask(d);
  endfunction

  // Applies one write, checks the same-cycle flags, then commits at the edge.
  task automatic do_write(int idx, int mode, int s, int d, logic [63:0] x, string req);
    bit lg = m_legal(mode, s, d);
    logic [63:0] v = m_value(mode, s, d, x);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_mode = 2'(mode);
    wr_src_size = 2'(s); wr_dst_size = 2'(d); wr_data = x;
    #1;
    chk({req, " R6 err flag"}, {63'd0, wr_ext_err}, {63'd0, !lg});
    chk({req, " R7 sp fault"}, {63'd0, sp_misalign},
        {63'd0, lg && idx == 4 && v[2:0] != 3'd0});
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd_check(int idx, logic [63:0] exp, string req);
    for (int sz = 0; sz < 4; sz++) begin
      rd_a_idx = 4'(idx); rd_a_size = 2'(sz);
      rd_b_idx = 4'(idx); rd_b_size = 2'(3 - sz);
      #1;
      chk({req, " R2 port A"}, rd_a_data, exp & m_mask(sz));
      chk({req, " R2 port B"}, rd_b_data, exp & m_mask(3 - sz));
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: all registers zero after reset
    for (int r = 0; r < 16; r++) rd_check(r, 64'd0, "R1 reset");
    chk("R6 idle no err", {63'd0, wr_ext_err}, 64'd0);

    // R3 R4 R5 R6: every mode and size pair, negative and positive operands
    for (int p = 0; p < 2; p++) begin
      for (int mode = 0; mode < 4; mode++) begin
        for (int s = 0; s < 4; s++) begin
          for (int d = 0; d < 4; d++) begin
            int r = (mode * 16 + s * 4 + d + p) % 16;
            logic [63:0] x = (p == 0) ? NEG : POS;
            logic [63:0] exp;
            do_write(r, 0, 0, 3, PRE, "preload R3");
            do_write(r, mode, s, d, x, "sweep R3 R4 R5");
            exp = m_legal(mode, s, d) ? m_value(mode, s, d, x) : PRE;
            rd_a_idx = 4'(r); rd_a_size = 2'd3; #1;
            chk($sformatf("R4 R5 R6 value m%0d s%0d d%0d", mode, s, d), rd_a_data, exp);
          end
        end
      end
    end

    // R2: sized reads of a full pattern on every register
    for (int r = 0; r < 16; r++) begin
      do_write(r, 0, 0, 3, NEG ^ {16{4'(r)}}, "fill R3");
      rd_check(r, NEG ^ {16{4'(r)}}, "R2 sizes");
    end

    // R7: stack pointer alignment
    do_write(4, 0, 0, 3, 64'h0000_0000_0000_1000, "R7 aligned");
    do_write(4, 0, 0, 3, 64'h0000_0000_0000_1003, "R7 misaligned");
    rd_a_idx = 4'd4; rd_a_size = 2'd3; #1;
    chk("R7 write still lands", rd_a_data, 64'h1003);
    do_write(4, 2, 0, 3, 64'h80, "R7 sign extend fault");
    do_write(5, 0, 0, 3, 64'h7, "R7 other register");
    do_write(4, 3, 0, 3, 64'h7, "R7 illegal pair no fault");

    // R8: read during write returns old value
    do_write(9, 0, 0, 3, 64'h1111_2222_3333_4444, "R8 setup");
    wr_en = 1'b1; wr_idx = 4'd9; wr_mode = 2'd0; wr_dst_size = 2'd3;
    wr_data = 64'h5555_6666_7777_8888;
    rd_a_idx = 4'd9; rd_a_size = 2'd3; rd_b_idx = 4'd9; rd_b_size = 2'd1;
    #1;
    chk("R8 old value A", rd_a_data, 64'h1111_2222_3333_4444);
    chk("R8 old value B", rd_b_data, 64'h4444);
    @(posedge clk); #1;
    wr_en = 1'b0; #1;
    chk("R8 new value", rd_a_data, 64'h5555_6666_7777_8888);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule